// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Status Flags

This block is a first-in first-out buffer for 9-bit words. Its write port and read port run on separate clocks with no required frequency relationship, and both ports may be active in the same cycle. Storage is an inferred memory whose depth is a parameter. The two pointers cross between the clock domains as Gray code through two-flop synchronisers. The write domain computes the full, half-full and almost-full flags. The read domain computes the empty and almost-empty flags.

Two thresholds set the almost flags: an almost-empty offset and an almost-full offset. A master reset loads both offsets with one of two default values, chosen by the level of the load pin during that reset. While the load pin is high, the offsets can be rewritten in whole 9-bit words on the data bus, or one bit at a time on a serial input. At master reset a mode pin selects one of two read timings. In strobed mode the reader pulls each word with read-enable. In fall-through mode the oldest word appears at the output on its own.

A partial reset empties the buffer but keeps the offsets and the mode. A retransmit input rewinds the read side to the first word written since the last reset. An output enable forces the data output to zero without disturbing the buffer.

Top module: `dual_clock_flag_fifo`

## Requirements
- R1: Words leave in the order they were written. In strobed mode, a read-enable sampled while the read side sees data loads the oldest word onto `dout`, visible after that read-clock edge.
- R2: A word written at a write-clock edge reaches the read side two read-clock edges later. In strobed mode `rd_stat` (1 = empty) falls after the second edge. In fall-through mode the word is on `dout` after the third edge.
- R3: The write-side level is the number of words written minus the number of words moved out of memory, as seen through the synchroniser. Full means the level equals DEPTH. A write while full, and a strobed read while the read side sees no data, change nothing.
- R4: `half_full` is 1 exactly when the write-side level is greater than DEPTH/2.
- R5: `almost_full` is 1 when the write-side level plus the almost-full offset is at least DEPTH. `almost_empty` is 1 when the read-side level is at most the almost-empty offset. The read-side level counts the word held on `dout` in fall-through mode.
- R6: A master reset with `load` low sets both offsets to DEF_A (default 7). A master reset with `load` high sets both offsets to DEF_B (default 1023).
- R7: With `load` high, each cycle with `wen` high writes `din` into the next 9-bit slice of the offsets and stores no data. The sequence is almost-empty offset, low slice first, then almost-full offset, low slice first, and it wraps around. Each offset is PW = log2(DEPTH)+1 bits wide and takes ceil(PW/9) slices.
- R8: With `load` high and `wen` low, each cycle with `sen` high shifts `si` into a 2*PW-bit chain. After 2*PW shifts, the first bit shifted in is bit 0 of the almost-empty offset and the last bit shifted in is the top bit of the almost-full offset.
- R9: A partial reset empties the buffer and clears `dout`. It keeps both offsets and the read mode.
- R10: In fall-through mode (`mode_sel` high during master reset), `rd_stat` is 1 while a valid word is on `dout` and `wr_stat` is 1 while the buffer is not full. In strobed mode `rd_stat` is 1 when empty and `wr_stat` is 1 when full. In fall-through mode a `ren` consumes the shown word.
- R11: A `rt` pulse sets the read position back to the first word since the last reset, ahead of any read in the same cycle. In fall-through mode that word is on `dout` one read-clock edge after the `rt` edge.
- R12: While `oe` is low, `dout` reads zero, and reads go on as usual.
- R13: A master reset empties the buffer, clears `dout` and captures the read mode from `mode_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst | input | 1 | Master reset, synchronous in each domain, active high |
| prst | input | 1 | Partial reset, synchronous in each domain, active high |
| wen | input | 1 | Write enable; offset slice write when `load` is high |
| load | input | 1 | Offset access select; default choice during master reset |
| sen | input | 1 | Serial offset shift enable |
| si | input | 1 | Serial offset bit |
| mode_sel | input | 1 | Read timing choice captured at master reset (1 = fall-through) |
| din | input | 9 | Write data or offset slice |
| ren | input | 1 | Read enable |
| rt | input | 1 | Retransmit request |
| oe | input | 1 | Output enable (0 forces `dout` to zero) |
| dout | output | 9 | Read data |
| rd_stat | output | 1 | Empty (strobed) or output-valid (fall-through) |
| wr_stat | output | 1 | Full (strobed) or room-available (fall-through) |
| half_full | output | 1 | Write-side level above half |
| almost_full | output | 1 | Programmable almost-full flag |
| almost_empty | output | 1 | Programmable almost-empty flag |

## Verification
The bench builds the block with DEPTH = 1024 and the default offsets 7 and 1023. With these values the pointers are 11 bits wide, so each offset takes two bus slices, and the slice sequencing and the serial chain length can both be checked. A full fill and drain, including the writes refused while full, fits within the cycle budget. One clock drives both ports, so the two-edge synchroniser latency can be checked against an integer model cycle by cycle.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
    localparam int DATA_W = 9;
    typedef enum logic {MODE_STD = 1'b0, MODE_FALL = 1'b1} rd_mode_e;
endpackage

// File: rtl/dcf_ptr_sync.sv
module dcf_ptr_sync #(
    parameter int PW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] gray_i,
    output logic [PW-1:0] bin_o
);
    typedef struct packed {
        logic [PW-1:0] s1;
        logic [PW-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = gray_i;
        st_d.s2 = st_q.s1;
        for (int i = 0; i < PW; i++) begin
            bin_o[i] = ^(st_q.s2 >> i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl import dcf_pkg::*; #(
    parameter int DEPTH = 2048,
    parameter int PW    = 12,
    parameter int DEF_A = 7,
    parameter int DEF_B = 1023
) (
    input  logic              clk,
    input  logic              mrst,
    input  logic              prst,
    input  logic              wen,
    input  logic              load,
    input  logic              sen,
    input  logic              si,
    input  logic              mode_sel,
    input  logic [DATA_W-1:0] din,
    input  logic [PW-1:0]     rbin_i,
    output logic [PW-1:0]     wgray_o,
    output logic [PW-2:0]     waddr_o,
    output logic              mem_we_o,
    output logic [PW-1:0]     ae_off_o,
    output logic              wr_stat_o,
    output logic              half_o,
    output logic              afull_o
);
    localparam int NW    = (PW + DATA_W - 1) / DATA_W;
    localparam int IW    = $clog2(2 * NW);
    localparam int EXT_W = NW * DATA_W;

    typedef struct packed {
        logic [PW-1:0] wbin;
        logic [PW-1:0] wgray;
        logic [PW-1:0] ae;
        logic [PW-1:0] af;
        logic [IW-1:0] pidx;
        rd_mode_e      mode;
    } wst_t;

    wst_t w_d, w_q;
    logic [PW-1:0]    wcount;
    logic             full_w, do_wr;
    logic [EXT_W-1:0] ext;
    logic [2*PW-1:0]  chain;
    int               wsel;

    always_comb begin
        wcount = w_q.wbin - rbin_i;
        full_w = (wcount == PW'(DEPTH));
        do_wr  = wen && !load && !full_w;
        w_d    = w_q;
        ext    = '0;
        chain  = {w_q.af, w_q.ae};
        wsel   = 0;
        if (mrst) begin
            w_d      = '0;
            w_d.ae   = load ? PW'(DEF_B) : PW'(DEF_A);
            w_d.af   = load ? PW'(DEF_B) : PW'(DEF_A);
            w_d.mode = mode_sel ? MODE_FALL : MODE_STD;
        end else if (prst) begin
            w_d.wbin  = '0;
            w_d.wgray = '0;
            w_d.pidx  = '0;
        end else begin
            if (load && wen) begin
                if (w_q.pidx < IW'(NW)) begin
                    ext  = EXT_W'(w_q.ae);
                    wsel = int'(w_q.pidx);
                end else begin
                    ext  = EXT_W'(w_q.af);
                    wsel = int'(w_q.pidx) - NW;
                end
                ext = (ext & ~(EXT_W'(9'h1FF) << (DATA_W * wsel)))
                    | (EXT_W'(din) << (DATA_W * wsel));
                if (w_q.pidx < IW'(NW)) w_d.ae = ext[PW-1:0];
                else                    w_d.af = ext[PW-1:0];
                w_d.pidx = (w_q.pidx == IW'(2 * NW - 1)) ? '0 : w_q.pidx + 1'b1;
            end else if (load && sen) begin
                chain  = {si, chain[2*PW-1:1]};
                w_d.ae = chain[PW-1:0];
                w_d.af = chain[2*PW-1:PW];
            end
            if (do_wr) begin
                w_d.wbin  = w_q.wbin + 1'b1;
                w_d.wgray = w_d.wbin ^ (w_d.wbin >> 1);
            end
        end
    end

    always_ff @(posedge clk) begin
        w_q <= w_d;
    end

    assign wgray_o   = w_q.wgray;
    assign waddr_o   = w_q.wbin[PW-2:0];
    assign mem_we_o  = do_wr && !mrst && !prst;
    assign ae_off_o  = w_q.ae;
    assign wr_stat_o = (w_q.mode == MODE_FALL) ? !full_w : full_w;
    assign half_o    = wcount > PW'(DEPTH / 2);
    assign afull_o   = ({1'b0, wcount} + {1'b0, w_q.af}) >= (PW + 1)'(DEPTH);

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (mrst || prst)
        (full_w && wen && !load) |=> $stable(w_q.wbin));
    // R3
    level_bound_chk: assert property (@(posedge clk) disable iff (mrst || prst)
        wcount <= PW'(DEPTH));
    // R2
    gray_step_chk: assert property (@(posedge clk) disable iff (mrst || prst)
        $countones(w_q.wgray ^ $past(w_q.wgray)) <= 1);
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl import dcf_pkg::*; #(
    parameter int DEPTH = 2048,
    parameter int PW    = 12
) (
    input  logic              clk,
    input  logic              mrst,
    input  logic              prst,
    input  logic              mode_sel,
    input  logic              ren,
    input  logic              rt,
    input  logic [PW-1:0]     wbin_i,
    input  logic [PW-1:0]     ae_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic [PW-2:0]     raddr_o,
    output logic [PW-1:0]     rgray_o,
    output logic [DATA_W-1:0] dout_o,
    output logic              rd_stat_o,
    output logic              aempty_o
);
    typedef struct packed {
        logic [PW-1:0]     rbin;
        logic [PW-1:0]     rgray;
        logic [DATA_W-1:0] dout;
        logic              ov;
        rd_mode_e          mode;
    } rst_t;

    rst_t r_d, r_q;
    logic [PW-1:0] rcount, level;
    logic          have, fall, fetch, consume;

    always_comb begin
        rcount  = wbin_i - r_q.rbin;
        have    = (rcount != '0);
        fall    = (r_q.mode == MODE_FALL);
        fetch   = fall ? ((!r_q.ov || ren) && have) : (ren && have);
        consume = fall && ren && r_q.ov;
        level   = rcount + PW'(fall && r_q.ov);
        r_d     = r_q;
        if (mrst) begin
            r_d      = '0;
            r_d.mode = mode_sel ? MODE_FALL : MODE_STD;
        end else if (prst) begin
            r_d.rbin  = '0;
            r_d.rgray = '0;
            r_d.dout  = '0;
            r_d.ov    = 1'b0;
        end else if (rt) begin
            r_d.rbin  = '0;
            r_d.rgray = '0;
            r_d.ov    = 1'b0;
        end else if (fetch) begin
            r_d.dout  = mem_rdata_i;
            r_d.rbin  = r_q.rbin + 1'b1;
            r_d.rgray = r_d.rbin ^ (r_d.rbin >> 1);
            r_d.ov    = fall;
        end else if (consume) begin
            r_d.ov = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign raddr_o   = r_q.rbin[PW-2:0];
    assign rgray_o   = r_q.rgray;
    assign dout_o    = r_q.dout;
    assign rd_stat_o = fall ? r_q.ov : !have;
    assign aempty_o  = level <= ae_i;

    // R3
    no_underflow_chk: assert property (@(posedge clk) disable iff (mrst || prst)
        (!fall && ren && !rt && !have) |=> $stable(r_q.rbin));
    // R10
    fall_hold_chk: assert property (@(posedge clk) disable iff (mrst || prst)
        (fall && r_q.ov && !ren && !rt) |=> (r_q.ov && $stable(r_q.dout)));
    // R11
    rewind_chk: assert property (@(posedge clk) disable iff (mrst || prst)
        rt |=> (r_q.rbin == '0 && !r_q.ov));
    // R3
    read_bound_chk: assert property (@(posedge clk) disable iff (mrst || prst)
        rcount <= PW'(DEPTH));
endmodule

// File: rtl/dual_clock_flag_fifo.sv
module dual_clock_flag_fifo import dcf_pkg::*; #(
    parameter int DEPTH = 2048,
    parameter int DEF_A = 7,
    parameter int DEF_B = 1023
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              mrst,
    input  logic              prst,
    input  logic              wen,
    input  logic              load,
    input  logic              sen,
    input  logic              si,
    input  logic              mode_sel,
    input  logic [DATA_W-1:0] din,
    input  logic              ren,
    input  logic              rt,
    input  logic              oe,
    output logic [DATA_W-1:0] dout,
    output logic              rd_stat,
    output logic              wr_stat,
    output logic              half_full,
    output logic              almost_full,
    output logic              almost_empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PW-1:0]     wgray, rgray, wbin_r, rbin_w, ae_off;
    logic [AW-1:0]     waddr, raddr;
    logic              mem_we;
    logic [DATA_W-1:0] rdata, dq;

    always_ff @(posedge wclk) begin
        if (mem_we) mem[waddr] <= din;
    end
    assign rdata = mem[raddr];

    dcf_ptr_sync #(.PW(PW)) u_r2w (
        .clk(wclk), .rst(mrst || prst), .gray_i(rgray), .bin_o(rbin_w));
    dcf_ptr_sync #(.PW(PW)) u_w2r (
        .clk(rclk), .rst(mrst || prst), .gray_i(wgray), .bin_o(wbin_r));

    dcf_wr_ctl #(.DEPTH(DEPTH), .PW(PW), .DEF_A(DEF_A), .DEF_B(DEF_B)) u_wr (
        .clk(wclk), .mrst(mrst), .prst(prst), .wen(wen), .load(load),
        .sen(sen), .si(si), .mode_sel(mode_sel), .din(din), .rbin_i(rbin_w),
        .wgray_o(wgray), .waddr_o(waddr), .mem_we_o(mem_we), .ae_off_o(ae_off),
        .wr_stat_o(wr_stat), .half_o(half_full), .afull_o(almost_full));

    dcf_rd_ctl #(.DEPTH(DEPTH), .PW(PW)) u_rd (
        .clk(rclk), .mrst(mrst), .prst(prst), .mode_sel(mode_sel), .ren(ren),
        .rt(rt), .wbin_i(wbin_r), .ae_i(ae_off), .mem_rdata_i(rdata),
        .raddr_o(raddr), .rgray_o(rgray), .dout_o(dq), .rd_stat_o(rd_stat),
        .aempty_o(almost_empty));

    assign dout = oe ? dq : '0;
endmodule

// File: tb/sim_dual_clock_flag_fifo.sv
module sim_dual_clock_flag_fifo;
    localparam int DEPTH = 1024;
    localparam int DEF_A = 7;
    localparam int DEF_B = 1023;
    localparam int PW    = 11;
    localparam int NW    = 2;
    localparam int MASK  = (1 << PW) - 1;

    logic clk = 1'b0;
    logic mrst = 1'b1, prst = 1'b0, wen = 1'b0, load = 1'b0, sen = 1'b0, si = 1'b0;
    logic mode_sel = 1'b0, ren = 1'b0, rt = 1'b0, oe = 1'b1;
    logic [8:0] din = '0;
    logic [8:0] dout;
    logic rd_stat, wr_stat, half_full, almost_full, almost_empty;

    always #5 clk = ~clk;

    dual_clock_flag_fifo #(.DEPTH(DEPTH), .DEF_A(DEF_A), .DEF_B(DEF_B)) u0 (
        .wclk(clk), .rclk(clk), .mrst(mrst), .prst(prst), .wen(wen), .load(load),
        .sen(sen), .si(si), .mode_sel(mode_sel), .din(din), .ren(ren), .rt(rt),
        .oe(oe), .dout(dout), .rd_stat(rd_stat), .wr_stat(wr_stat),
        .half_full(half_full), .almost_full(almost_full), .almost_empty(almost_empty));

    // behavioural model
    int w_tot, r_tot, ws1, ws2, rs1, rs2, ae_m, af_m, pidx_m, dout_m;
    bit mode_m, ov_m, started;
    logic [8:0] hist[$];
    int compared = 0, mismatched = 0, cycles = 0;
    string tag = "R13";

    task automatic clear_data();
        w_tot = 0; r_tot = 0; ws1 = 0; ws2 = 0; rs1 = 0; rs2 = 0;
        ov_m = 0; dout_m = 0; pidx_m = 0;
        hist.delete();
    endtask

    always @(posedge clk) begin
        int wc, rc, n_ws1, n_rs1, sel, wsl, cat;
        bit full_m, have, fetch;
        started = 1;
        if (mrst) begin
            clear_data();
            ae_m = load ? DEF_B : DEF_A;
            af_m = ae_m;
            mode_m = mode_sel;
        end else if (prst) begin
            clear_data();
        end else begin
            wc = w_tot - rs2; full_m = (wc == DEPTH);
            rc = ws2 - r_tot; have = (rc != 0);
            n_ws1 = w_tot; n_rs1 = r_tot;
            if (load && wen) begin
                sel = (pidx_m < NW) ? ae_m : af_m;
                wsl = (pidx_m < NW) ? pidx_m : pidx_m - NW;
                sel = ((sel & ~(511 << (9 * wsl))) | (int'(din) << (9 * wsl))) & MASK;
                if (pidx_m < NW) ae_m = sel; else af_m = sel;
                pidx_m = (pidx_m + 1) % (2 * NW);
            end else if (load && sen) begin
                cat = (af_m << PW) | ae_m;
                cat = (cat >> 1) | (int'(si) << (2 * PW - 1));
                ae_m = cat & MASK;
                af_m = (cat >> PW) & MASK;
            end else if (wen && !load && !full_m) begin
                hist.push_back(din);
                w_tot++;
            end
            if (rt) begin
                r_tot = 0; ov_m = 0;
            end else begin
                fetch = mode_m ? ((!ov_m || ren) && have) : (ren && have);
                if (fetch) begin
                    dout_m = hist[r_tot]; r_tot++; ov_m = mode_m;
                end else if (mode_m && ren && ov_m) begin
                    ov_m = 0;
                end
            end
            ws2 = ws1; ws1 = n_ws1; rs2 = rs1; rs1 = n_rs1;
        end
    end

    task automatic cmp(string what, int act, int exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    always @(negedge clk) begin
        int wc, rc, lvl;
        bit full_m;
        #3;
        cycles++;
        if (cycles > 100000) begin
            mismatched++;
            $display("FAIL watchdog expired tag=%s actual=%0d expected=%0d", tag, cycles, 100000);
            finish_run();
        end
        if (started) begin
            wc = w_tot - rs2; full_m = (wc == DEPTH);
            rc = ws2 - r_tot; lvl = rc + ((mode_m && ov_m) ? 1 : 0);
            cmp("dout(R1)", int'(dout), oe ? dout_m : 0);
            cmp("rd_stat(R2)", int'(rd_stat), mode_m ? int'(ov_m) : int'(rc == 0));
            cmp("wr_stat(R10)", int'(wr_stat), mode_m ? int'(!full_m) : int'(full_m));
            cmp("half_full(R4)", int'(half_full), int'(wc > DEPTH / 2));
            cmp("almost_full(R5)", int'(almost_full), int'(wc + af_m >= DEPTH));
            cmp("almost_empty(R5)", int'(almost_empty), int'(lvl <= ae_m));
        end
    end

    task automatic idle(int n);
        wen = 0; ren = 0; load = 0; sen = 0; rt = 0;
        repeat (n) @(negedge clk);
    endtask
    task automatic do_mrst(bit ldv, bit mv);
        mrst = 1; load = ldv; mode_sel = mv;
        repeat (3) @(negedge clk);
        mrst = 0; load = 0;
    endtask
    task automatic do_prst();
        prst = 1; repeat (3) @(negedge clk); prst = 0;
    endtask
    task automatic wr(int n, int base);
        for (int i = 0; i < n; i++) begin
            wen = 1; din = 9'(base + i); @(negedge clk);
        end
        wen = 0;
    endtask
    task automatic rd(int n);
        ren = 1; repeat (n) @(negedge clk); ren = 0;
    endtask
    task automatic pload(int w);
        load = 1; wen = 1; din = 9'(w); @(negedge clk); wen = 0; load = 0;
    endtask
    task automatic sload(int ae, int af);
        load = 1; sen = 1;
        for (int i = 0; i < 2 * PW; i++) begin
            si = (i < PW) ? ae[i] : af[i - PW];
            @(negedge clk);
        end
        sen = 0; load = 0; si = 0;
    endtask

    initial begin
        tag = "R13"; do_mrst(0, 0); idle(2);
        tag = "R2";  wr(1, 9'h1A5); idle(4);
        tag = "R1";  wr(5, 20); idle(3); rd(3);
        wen = 1; ren = 1; din = 9'h55; @(negedge clk); idle(3); rd(3);
        tag = "R3";  rd(3); idle(2);
        tag = "R6";  wr(9, 100); idle(3); rd(9); idle(3);
        tag = "R7";  pload(88); pload(1); pload(8); pload(1);
        tag = "R5";  wr(DEPTH + 6, 7); idle(4);
        tag = "R4";  rd(DEPTH / 2 + 1); idle(3);
        tag = "R12"; oe = 0; rd(4); oe = 1; rd(DEPTH); idle(3);
        tag = "R8";  sload(2, 4); wr(8, 300); idle(3); rd(8); idle(3);
        wr(DEPTH, 50); idle(3);
        tag = "R9";  do_prst(); idle(3); wr(6, 400); idle(3); rd(3); idle(2);
        tag = "R11"; do_prst(); wr(4, 200); idle(3); rd(4); rt = 1; ren = 1;
        @(negedge clk); rt = 0; idle(3); rd(4); idle(3);
        tag = "R10"; do_mrst(1, 1); idle(2); wr(3, 60); idle(5);
        rd(1); idle(2); ren = 1; wen = 1; din = 9'h77; @(negedge clk); idle(4);
        rd(3); idle(3); wr(DEPTH, 1); idle(4); rd(DEPTH + 2); idle(3);
        tag = "R11"; do_prst(); wr(5, 90); idle(4); rd(2); rt = 1;
        @(negedge clk); rt = 0; idle(3); rd(6); idle(3);
        tag = "R9"; do_prst(); wr(2, 33); idle(5); rd(2); idle(3);
        tag = "R13"; do_mrst(0, 0); idle(3); wr(2, 5); idle(3); rd(2); idle(3);
        finish_run();
    end
endmodule